// File: doc/BRIEF.md
# Cell-Buffered Transmit Port for a Cell Bus

This block sits between an internal cell assembler and an outgoing cell bus of the UTOPIA kind. The assembler hands over cells one byte per clock. Each cell is 53 bytes: four header bytes, one header-check byte and 48 payload bytes. An eight-slot cell buffer lets the assembler keep working while the bus is stalled. The bus side sends a cell only once the whole cell is stored, so a cell is never starved part-way through.

A static mode input picks the bus width. In 8-bit mode a cell is 53 bus words on the low lane, and the high lane is held at zero. In 16-bit mode a cell is 27 bus words (54 bytes). The earlier byte of each pair goes on the high lane. A padding word follows the two header words and holds the header-check byte on the high lane and zero on the low lane. With each word the block drives a start-of-cell flag, a valid strobe and an odd parity bit over the active lanes. The receiving device controls the flow through two inputs: a cell-space flag, which lets a new cell begin, and a per-word enable, which accepts the word on the bus.

Top module: `utx_cell_port`

## Requirements
- R1: After reset, txValid, txSoc and wrFull are 0, txData is 0 and txPar is 1.
- R2: In 8-bit mode (mode16=0), a cell goes out as 53 words. Word k carries byte k of the cell on txData[7:0], and txData[15:8] is 0.
- R3: In 16-bit mode (mode16=1), a cell goes out as 27 words with the earlier byte on txData[15:8]. Words 0 and 1 carry bytes 0-1 and 2-3. Word 2 is {byte 4, 8'h00}. Word k, for k of 3 or more, carries bytes 2k-1 and 2k.
- R4: txPar makes the count of ones odd. It counts txData[7:0] together with txPar in 8-bit mode, and txData[15:0] together with txPar in 16-bit mode.
- R5: txSoc is 1 on the first word of each cell and on no other word.
- R6: A cell begins only when a complete cell is stored and rxClav is 1. Once it has begun, txValid stays 1 until its last word has been accepted.
- R7: A word is accepted on a rising edge where txValid and rxEnable are both 1. While rxEnable is 0, the word on the bus is held unchanged and the cell resumes from that word, with nothing dropped or repeated.
- R8: wrFull is 1 when all 8 slots hold a cell. A byte written while wrFull is 1 is discarded and never reaches the bus.
- R9: With rxClav held at 0, the assembler can store 8 complete cells, and they leave later in the order written.
- R10: When a cell completes on the write side in the same cycle as the bus accepts the last word of another cell, the stored-cell count stays correct. Exactly the new cell then leaves next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode16 | input | 1 | Bus width: 1 = 16-bit, 0 = 8-bit; change only while the block is empty |
| wrValid | input | 1 | Assembler presents a cell byte this cycle |
| wrData | input | 8 | Cell byte from the assembler |
| wrFull | output | 1 | All cell slots are occupied |
| rxClav | input | 1 | Receiver has space for a new cell |
| rxEnable | input | 1 | Receiver accepts the current word |
| txData | output | 16 | Bus word |
| txSoc | output | 1 | First word of a cell |
| txValid | output | 1 | Bus word is valid |
| txPar | output | 1 | Odd parity over the active lanes |

## Verification
Two things can happen on the same edge: the writer commits a finished cell, and the bus releases the slot of the cell it has just finished. The bench provokes this in 8-bit mode. It starts a one-cell drain with rxEnable held high, and starts a new 53-byte write exactly one cycle later, so that the 53rd byte and the last accepted word land on the same edge. The result is judged at the ports. The next drain must return exactly the new cell, and afterwards no further cell may appear while rxClav stays high.

// File: rtl/utx_pkg.sv
package utx_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic wrEn;   // store wrData at the write address
    logic drive;  // a cell word is on the bus
  } utxStrobes_t;

endpackage

// File: rtl/utx_ctl.sv
module utx_ctl
  import utx_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int CELL_BYTES = 53,
  parameter int WORDS16    = 27,
  parameter int ADDR_W     = 9,
  parameter int IDX_W      = 6,
  parameter int SLOT_W     = 3,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode16,
  input  logic              wrValid,
  input  logic              rxClav,
  input  logic              rxEnable,
  output utxStrobes_t       strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdBase,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              wrFull,
  output logic              txValid,
  output logic              txSoc
);

  localparam logic [IDX_W-1:0]  LAST_BYTE = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0]  LAST_W8   = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0]  LAST_W16  = IDX_W'(WORDS16 - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(SLOTS);

  logic [SLOT_W-1:0] wrSlot, rdSlot;
  logic [CNT_W-1:0]  cellCount;
  logic [IDX_W-1:0]  wrIdx;
  logic              inCell;
  logic              wrAccept, commit, xfer, release_, start;
  logic [IDX_W-1:0]  lastWord;

  assign wrFull   = (cellCount == FULL_CNT);
  assign wrAccept = wrValid && !wrFull;
  assign commit   = wrAccept && (wrIdx == LAST_BYTE);
  assign lastWord = mode16 ? LAST_W16 : LAST_W8;
  assign xfer     = inCell && rxEnable;
  assign release_ = xfer && (wordIdx == lastWord);
  assign start    = !inCell && (cellCount != '0) && rxClav;

  // Writer: byte index within the cell and slot pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx  <= '0;
      wrSlot <= '0;
    end else if (wrAccept) begin
      if (commit) begin
        wrIdx  <= '0;
        wrSlot <= (wrSlot == LAST_SLOT) ? '0 : wrSlot + 1'b1;
      end else begin
        wrIdx <= wrIdx + 1'b1;
      end
    end
  end

  // Reader: cell framing on the bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCell  <= 1'b0;
      wordIdx <= '0;
      rdSlot  <= '0;
    end else if (start) begin
      inCell  <= 1'b1;
      wordIdx <= '0;
    end else if (release_) begin
      inCell  <= 1'b0;
      wordIdx <= '0;
      rdSlot  <= (rdSlot == LAST_SLOT) ? '0 : rdSlot + 1'b1;
    end else if (xfer) begin
      wordIdx <= wordIdx + 1'b1;
    end
  end

  // Stored-cell count: a commit and a release on the same edge cancel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellCount <= '0;
    end else begin
      unique case ({commit, release_})
        2'b10:   cellCount <= cellCount + 1'b1;
        2'b01:   cellCount <= cellCount - 1'b1;
        default: cellCount <= cellCount;
      endcase
    end
  end

  assign wrAddr  = ADDR_W'(wrSlot * CELL_BYTES) + ADDR_W'(wrIdx);
  assign rdBase  = ADDR_W'(rdSlot * CELL_BYTES);
  assign txValid = inCell;
  assign txSoc   = inCell && (wordIdx == '0);

  always_comb begin
    strobes       = '0;
    strobes.wrEn  = wrAccept;
    strobes.drive = inCell;
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cellCount <= FULL_CNT);

  // R6
  valid_needs_cell_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (cellCount != '0));

  // R8
  full_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrFull && !release_) |=> wrFull);

endmodule

// File: rtl/utx_dp.sv
module utx_dp
  import utx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SLOTS      = 8,
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4,
  parameter int ADDR_W     = 9,
  parameter int IDX_W      = 6
) (
  input  logic                clk,
  input  utxStrobes_t         strobes,
  input  logic                mode16,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdBase,
  input  logic [IDX_W-1:0]    wordIdx,
  output logic [2*BYTE_W-1:0] txData,
  output logic                txPar
);

  localparam int DEPTH     = SLOTS * CELL_BYTES;
  localparam int HDR_WORDS = HDR_BYTES / 2;
  localparam logic [IDX_W-1:0] PAD_IDX = IDX_W'(HDR_WORDS);

  logic [BYTE_W-1:0] cellMem [DEPTH];
  logic [IDX_W-1:0]  firstOff;
  logic [ADDR_W-1:0] hiAddr, loAddr;
  logic [BYTE_W-1:0] hiByte, loByte;
  logic [2*BYTE_W-1:0] word;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) cellMem[wrAddr] <= wrData;
  end

  // Byte offset of the word's first byte within the cell
  always_comb begin
    if (!mode16)                firstOff = wordIdx;
    else if (wordIdx <= PAD_IDX) firstOff = wordIdx << 1;
    else                        firstOff = (wordIdx << 1) - 1'b1;
  end

  assign hiAddr = rdBase + ADDR_W'(firstOff);
  assign loAddr = hiAddr + 1'b1;
  assign hiByte = (int'(hiAddr) < DEPTH) ? cellMem[hiAddr] : '0;
  assign loByte = (int'(loAddr) < DEPTH) ? cellMem[loAddr] : '0;

  always_comb begin
    if (!strobes.drive)          word = '0;
    else if (!mode16)            word = {{BYTE_W{1'b0}}, hiByte};
    else if (wordIdx == PAD_IDX) word = {hiByte, {BYTE_W{1'b0}}};
    else                         word = {hiByte, loByte};
  end

  assign txData = word;
  assign txPar  = mode16 ? ~(^word) : ~(^word[BYTE_W-1:0]);

endmodule

// File: rtl/utx_cell_port.sv
module utx_cell_port
  import utx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SLOTS      = 8,
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mode16,
  input  logic                wrValid,
  input  logic [BYTE_W-1:0]   wrData,
  output logic                wrFull,
  input  logic                rxClav,
  input  logic                rxEnable,
  output logic [2*BYTE_W-1:0] txData,
  output logic                txSoc,
  output logic                txValid,
  output logic                txPar
);

  localparam int WORDS16 = (CELL_BYTES + 1) / 2;
  localparam int ADDR_W  = $clog2(SLOTS * CELL_BYTES);
  localparam int IDX_W   = $clog2(CELL_BYTES);
  localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W   = $clog2(SLOTS + 1);

  utxStrobes_t       strobes;
  logic [ADDR_W-1:0] wrAddr, rdBase;
  logic [IDX_W-1:0]  wordIdx;

  utx_ctl #(
    .SLOTS(SLOTS), .CELL_BYTES(CELL_BYTES), .WORDS16(WORDS16),
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .mode16(mode16), .wrValid(wrValid),
    .rxClav(rxClav), .rxEnable(rxEnable), .strobes(strobes),
    .wrAddr(wrAddr), .rdBase(rdBase), .wordIdx(wordIdx),
    .wrFull(wrFull), .txValid(txValid), .txSoc(txSoc)
  );

  utx_dp #(
    .BYTE_W(BYTE_W), .SLOTS(SLOTS), .CELL_BYTES(CELL_BYTES),
    .HDR_BYTES(HDR_BYTES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .strobes(strobes), .mode16(mode16), .wrAddr(wrAddr),
    .wrData(wrData), .rdBase(rdBase), .wordIdx(wordIdx),
    .txData(txData), .txPar(txPar)
  );

  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !rxEnable) |=> (txValid && $stable(txData) && $stable(txSoc)));

  // R5
  soc_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && rxEnable && txSoc) |=> !txSoc);

endmodule

// File: tb/sim_utx_cell_port.sv
module sim_utx_cell_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mode16 = 1'b0;
  logic        wrValid = 1'b0;
  logic [7:0]  wrData = '0;
  logic        wrFull;
  logic        rxClav = 1'b0;
  logic        rxEnable = 1'b0;
  logic [15:0] txData;
  logic        txSoc, txValid, txPar;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  utx_cell_port u0 (
    .clk(clk), .rstN(rstN), .mode16(mode16), .wrValid(wrValid),
    .wrData(wrData), .wrFull(wrFull), .rxClav(rxClav), .rxEnable(rxEnable),
    .txData(txData), .txSoc(txSoc), .txValid(txValid), .txPar(txPar)
  );

  // Vector fields: {mode16, stall, seed[7:0], expected word count[7:0]}
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd3,   8'd53},
    {1'b0, 1'b1, 8'd17,  8'd53},
    {1'b1, 1'b0, 8'd42,  8'd27},
    {1'b1, 1'b1, 8'd99,  8'd27},
    {1'b0, 1'b1, 8'd200, 8'd53},
    {1'b1, 1'b1, 8'd7,   8'd27}
  };

  logic [15:0] gotData [64];
  logic        gotSoc  [64];
  logic        gotPar  [64];
  int gotN, holdBad, gapBad;

  function automatic logic [7:0] cb(int s, int i);
    return 8'((s * 37) + (i * 11) + (i >> 2) + (s >> 1));
  endfunction

  function automatic logic [15:0] expWord(bit m16, int s, int w);
    if (!m16)   return {8'h00, cb(s, w)};
    if (w < 2)  return {cb(s, 2*w), cb(s, 2*w + 1)};
    if (w == 2) return {cb(s, 4), 8'h00};
    return {cb(s, 2*w - 1), cb(s, 2*w)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge
  task automatic writeBytes(int s, int from, int upto);
    for (int i = from; i < upto; i++) begin
      wrValid = 1'b1;
      wrData  = cb(s, i);
      @(negedge clk);
    end
    wrValid = 1'b0;
  endtask

  task automatic recvCell(int expW, bit stall);
    int k = 0;
    bit prevHeld = 1'b0;
    logic [15:0] prevData = '0;
    gotN = 0; holdBad = 0; gapBad = 0;
    rxClav = 1'b1;
    while (gotN < expW && k < 2000) begin
      bit en = stall ? ((k % 4) != 1) : 1'b1;
      rxEnable = en;
      if (prevHeld && (!txValid || txData !== prevData)) holdBad++;
      if (gotN > 0 && !txValid) gapBad++;
      if (txValid && en) begin
        gotData[gotN] = txData;
        gotSoc[gotN]  = txSoc;
        gotPar[gotN]  = txPar;
        gotN++;
      end
      prevHeld = txValid && !en;
      prevData = txData;
      @(negedge clk);
      k++;
    end
    rxClav = 1'b0;
    rxEnable = 1'b0;
  endtask

  task automatic checkCell(bit m16, int s, int expW, string req);
    int dataBad = -1, parBad = -1, socBad = -1;
    check(gotN == expW, {req, " word count"}, gotN, expW);
    for (int w = 0; w < gotN && w < 64; w++) begin
      logic expP;
      expP = m16 ? ~(^gotData[w]) : ~(^gotData[w][7:0]);
      if (dataBad < 0 && gotData[w] !== expWord(m16, s, w)) dataBad = w;
      if (parBad < 0 && gotPar[w] !== expP) parBad = w;
      if (socBad < 0 && gotSoc[w] !== (w == 0)) socBad = w;
    end
    if (dataBad >= 0)
      check(1'b0, {req, " data"}, gotData[dataBad], expWord(m16, s, dataBad));
    else check(1'b1, req, 0, 0);
    check(parBad < 0, "R4 parity", parBad, -1);
    check(socBad < 0, "R5 start-of-cell", socBad, -1);
    check(gapBad == 0, "R6 no starvation", gapBad, 0);
  endtask

  task automatic checkIdle(int cycles, string req);
    int seen = 0;
    rxClav = 1'b1;
    rxEnable = 1'b1;
    repeat (cycles) begin
      @(negedge clk);
      if (txValid) seen++;
    end
    rxClav = 1'b0;
    rxEnable = 1'b0;
    check(seen == 0, req, seen, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({txValid, txSoc, wrFull} == 3'b000, "R1 flags", {txValid, txSoc, wrFull}, 0);
    check(txData == 16'h0 && txPar == 1'b1, "R1 bus", {txData, txPar}, 1);

    // Table: R2/R3 by mode, R7 with stall
    for (int v = 0; v < NVEC; v++) begin
      bit m16 = VEC[v][17];
      bit st  = VEC[v][16];
      int sd  = int'(VEC[v][15:8]);
      int ew  = int'(VEC[v][7:0]);
      mode16 = m16;
      @(negedge clk);
      writeBytes(sd, 0, 53);
      recvCell(ew, st);
      checkCell(m16, sd, ew, m16 ? "R3" : "R2");
      check(holdBad == 0, "R7 hold while disabled", holdBad, 0);
      if (!m16)
        for (int w = 0; w < gotN && w < 64; w++)
          if (gotData[w][15:8] != 8'h00) begin
            check(1'b0, "R2 upper lane", gotData[w], gotData[w] & 16'h00ff);
            break;
          end
    end

    // R6: partial cell is not offered
    mode16 = 1'b0;
    @(negedge clk);
    writeBytes(55, 0, 20);
    checkIdle(12, "R6 partial cell held back");
    writeBytes(55, 20, 53);
    recvCell(53, 1'b1);
    checkCell(1'b0, 55, 53, "R6");

    // R9 fill with bus halted, R8 full and ignored write
    for (int c = 0; c < 8; c++) begin
      check(!wrFull, "R9 slot free", wrFull, 0);
      writeBytes(c + 60, 0, 53);
    end
    check(wrFull, "R8 full after 8 cells", wrFull, 1);
    writeBytes(250, 0, 53);
    check(wrFull, "R8 still full", wrFull, 1);
    for (int c = 0; c < 8; c++) begin
      recvCell(53, c[0]);
      checkCell(1'b0, c + 60, 53, "R9 order");
    end
    check(!wrFull, "R8 full cleared", wrFull, 0);
    checkIdle(10, "R8 ignored cell absent");

    // R10 commit and release on the same edge
    writeBytes(11, 0, 53);
    fork
      recvCell(53, 1'b0);
      begin
        @(negedge clk);
        writeBytes(12, 0, 53);
      end
    join
    checkCell(1'b0, 11, 53, "R10 first cell");
    @(negedge clk);
    recvCell(53, 1'b0);
    checkCell(1'b0, 12, 53, "R10 new cell");
    checkIdle(10, "R10 count returns to zero");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule